// File: doc/BRIEF.md
# Multi-Mode Input Capture Timer

An up-counting timer that timestamps transitions on an external timer pin. A two-stage synchronizer and an edge detector turn the pin into single-cycle capture strobes. The selected edge direction copies the running count into a capture register, which is read as two byte halves. The count is compared against a programmable limit, and a match is the block's reload event.

Three capture modes share one counter and differ in how it restarts. Free mode never restarts the count. Restart mode goes back to 0001h on a capture or on a limit match. Gated mode arms on the first edge, captures on each later edge, and stops for good at a limit match. A two-bit selector chooses which event kinds raise the one-cycle interrupt pulse. A status bit tells whether the last reported interrupt came from a capture or from a reload. An output pin starts at the polarity level and flips on every reload event.

Top module: `cap_timer`

## Requirements
- R1: With `edge_pol`=0 only a rising pin transition captures, and with `edge_pol`=1 only a falling one does. The opposite transition leaves the capture register and `irq` untouched.
- R2: A pin change that is set up before rising clock edge n updates the capture register and raises `irq` after edge n+2. The value stored is the count held between edges n+1 and n+2.
- R3: `capt_hi` is bits 15:8 and `capt_lo` is bits 7:0 of the captured count. The register changes only on a capture event.
- R4: `irq_src_sel` bit 0 enables capture interrupts and bit 1 enables reload interrupts. `irq` is a pulse of one cycle per event cycle.
- R5: `irq_is_capture` becomes 1 on an interrupting capture and 0 on an interrupting reload. Masked events leave it unchanged. If a capture and a reload that both interrupt fall in one cycle, it becomes 1.
- R6: In free mode (`cap_mode`=00, and also 11) the counter holds 0001h on the first cycle after enable and then increments every cycle, wrapping from FFFFh to 0000h. The cycle in which count equals `limit_val` is a reload event, and counting continues without a restart.
- R7: In restart mode (`cap_mode`=01) a capture or a limit match loads the counter with 0001h. When both happen in the same cycle, the capture wins: there is no reload event and the output pin does not flip.
- R8: In gated mode (`cap_mode`=10) the first selected edge only starts the counter at 0001h, with no capture. Later edges capture and restart the count at 0001h. A limit match is a reload event, after which the timer stops until it is disabled and enabled again.
- R9: The output pin level equals `edge_pol` while disabled and at enable, and it flips on every reload event. `tmr_out` shows that level when `pin_out_en`=1 and is 0 otherwise.
- R10: A pin level present when `timer_en` rises is not taken as an edge. While `timer_en`=0 no capture or interrupt occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| timer_en | input | 1 | Run enable, level sensitive |
| cap_mode | input | 2 | 00 free, 01 restart, 10 gated |
| edge_pol | input | 1 | Capture edge select and initial output level |
| irq_src_sel | input | 2 | Bit 0 capture interrupts, bit 1 reload interrupts |
| pin_out_en | input | 1 | Drives the toggling level onto tmr_out |
| limit_val | input | 16 | Reload/compare value |
| tmr_in | input | 1 | Asynchronous timer input pin |
| capt_hi | output | 8 | Captured count, upper byte |
| capt_lo | output | 8 | Captured count, lower byte |
| irq | output | 1 | Interrupt pulse |
| irq_is_capture | output | 1 | 1 when the last interrupt was a capture |
| tmr_out | output | 1 | Timer output pin |

## Verification
The bench sweeps the capture point over many cycle offsets. A design with the wrong synchronizer depth would store a count off by one. A design that restarted the counter at 0000h would shift every later timestamp. The bench drives a capture and a limit match into the same cycle in both free and restart modes. A wrong priority would leave the status bit at 0, or would flip the output pin in restart mode. The bench also runs across a full 16-bit wrap and tests the gated mode's stop at the limit. It checks that the pin level present at enable and the wrong-direction transitions are ignored. A design that got these wrong would report extra captures.

// File: rtl/cap_timer_pkg.sv
package cap_timer_pkg;

    localparam logic [1:0] MODE_FREE    = 2'b00;
    localparam logic [1:0] MODE_RESTART = 2'b01;
    localparam logic [1:0] MODE_GATED   = 2'b10;

    localparam int IRQ_CAP_BIT = 0;
    localparam int IRQ_REL_BIT = 1;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RUN  = 2'd2,
        ST_DONE = 2'd3
    } run_state_t;

endpackage

// File: rtl/cap_timer_edge.sv
module cap_timer_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic fall_sel_i,
    output logic edge_o
);

    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d      = q;
        d.s1   = pin_i;
        d.s2   = q.s1;
        d.prev = q.s2;
        edge_o = fall_sel_i ? (q.prev & ~q.s2) : (~q.prev & q.s2);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |=> (!edge_o || $changed(fall_sel_i))); // R1

endmodule

// File: rtl/cap_timer_core.sv
module cap_timer_core
    import cap_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [1:0]       mode_i,
    input  logic             pol_i,
    input  logic [1:0]       sel_i,
    input  logic [CNT_W-1:0] limit_i,
    input  logic             edge_i,
    output logic [CNT_W-1:0] cap_o,
    output logic             irq_o,
    output logic             src_o,
    output logic             tout_o
);

    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        run_state_t       st;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] cap;
        logic             irq;
        logic             src;
        logic             tout;
    } core_t;

    core_t q, d;
    logic  hit;
    logic  cap_ev;
    logic  rel_ev;
    logic  cap_irq;
    logic  rel_irq;

    always_comb begin
        d      = q;
        d.irq  = 1'b0;
        hit    = (q.cnt == limit_i);
        cap_ev = 1'b0;
        rel_ev = 1'b0;

        if (!en_i) begin
            d.st   = ST_IDLE;
            d.tout = pol_i;
        end else begin
            unique case (q.st)
                ST_IDLE: begin
                    d.cnt  = CNT_ONE;
                    d.st   = (mode_i == MODE_GATED) ? ST_WAIT : ST_RUN;
                    d.tout = pol_i;
                end
                ST_WAIT: begin
                    if (edge_i) begin
                        d.cnt = CNT_ONE;
                        d.st  = ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (mode_i == MODE_RESTART) begin
                        cap_ev = edge_i;
                        rel_ev = hit && !edge_i;
                        d.cnt  = (cap_ev || rel_ev) ? CNT_ONE : q.cnt + CNT_ONE;
                    end else if (mode_i == MODE_GATED) begin
                        cap_ev = edge_i;
                        rel_ev = hit && !edge_i;
                        if (cap_ev) begin
                            d.cnt = CNT_ONE;
                        end else if (rel_ev) begin
                            d.st  = ST_DONE;
                        end else begin
                            d.cnt = q.cnt + CNT_ONE;
                        end
                    end else begin
                        cap_ev = edge_i;
                        rel_ev = hit;
                        d.cnt  = q.cnt + CNT_ONE;
                    end
                end
                default: begin
                end
            endcase
        end

        cap_irq = cap_ev && sel_i[IRQ_CAP_BIT];
        rel_irq = rel_ev && sel_i[IRQ_REL_BIT];

        if (cap_ev) d.cap  = q.cnt;
        if (rel_ev) d.tout = ~q.tout;
        d.irq = cap_irq || rel_irq;
        if (cap_irq)      d.src = 1'b1;
        else if (rel_irq) d.src = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign cap_o  = q.cap;
    assign irq_o  = q.irq;
    assign src_o  = q.src;
    assign tout_o = q.tout;

    AST_RESTART_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_ev && mode_i != MODE_FREE && mode_i != 2'b11) |=> (q.cnt == CNT_ONE)); // R7

    AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_ev |=> $stable(q.cap)); // R3

    AST_SRC_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_ev && sel_i[IRQ_CAP_BIT]) |=> q.src); // R5

    AST_TOUT_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && q.st != ST_IDLE && !rel_ev) |=> $stable(q.tout)); // R9

    AST_QUIET_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE) |=> !q.irq); // R10

    AST_DONE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_DONE && en_i) |=> ($stable(q.cnt) && !q.irq)); // R8

endmodule

// File: rtl/cap_timer.sv
module cap_timer
    import cap_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               timer_en,
    input  logic [1:0]         cap_mode,
    input  logic               edge_pol,
    input  logic [1:0]         irq_src_sel,
    input  logic               pin_out_en,
    input  logic [CNT_W-1:0]   limit_val,
    input  logic               tmr_in,
    output logic [CNT_W/2-1:0] capt_hi,
    output logic [CNT_W/2-1:0] capt_lo,
    output logic               irq,
    output logic               irq_is_capture,
    output logic               tmr_out
);

    localparam int HALF_W = CNT_W / 2;

    logic             edge_s;
    logic [CNT_W-1:0] cap_s;
    logic             tout_s;

    cap_timer_edge u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_i      (tmr_in),
        .fall_sel_i (edge_pol),
        .edge_o     (edge_s)
    );

    cap_timer_core #(.CNT_W(CNT_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (timer_en),
        .mode_i  (cap_mode),
        .pol_i   (edge_pol),
        .sel_i   (irq_src_sel),
        .limit_i (limit_val),
        .edge_i  (edge_s),
        .cap_o   (cap_s),
        .irq_o   (irq),
        .src_o   (irq_is_capture),
        .tout_o  (tout_s)
    );

    assign capt_hi = cap_s[CNT_W-1:HALF_W];
    assign capt_lo = cap_s[HALF_W-1:0];
    assign tmr_out = pin_out_en ? tout_s : 1'b0;

endmodule

// File: tb/cap_timer_test.sv
module cap_timer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        timer_en = 1'b0;
    logic [1:0]  cap_mode = 2'b00;
    logic        edge_pol = 1'b0;
    logic [1:0]  irq_src_sel = 2'b00;
    logic        pin_out_en = 1'b0;
    logic [15:0] limit_val = 16'd0;
    logic        tmr_in = 1'b0;
    logic [7:0]  capt_hi;
    logic [7:0]  capt_lo;
    logic        irq;
    logic        irq_is_capture;
    logic        tmr_out;

    int checks = 0;
    int errors = 0;
    int t = 0;
    int cycles = 0;
    bit done = 0;

    cap_timer uut (
        .clk(clk), .rst_n(rst_n), .timer_en(timer_en), .cap_mode(cap_mode),
        .edge_pol(edge_pol), .irq_src_sel(irq_src_sel), .pin_out_en(pin_out_en),
        .limit_val(limit_val), .tmr_in(tmr_in), .capt_hi(capt_hi), .capt_lo(capt_lo),
        .irq(irq), .irq_is_capture(irq_is_capture), .tmr_out(tmr_out)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int capv();
        return int'({capt_hi, capt_lo});
    endfunction

    task automatic go(input int j);
        repeat (j - t) @(negedge clk);
        t = j;
    endtask

    task automatic start(input logic [1:0] m, input logic p, input logic [1:0] s,
                         input logic [15:0] lim, input logic lvl);
        @(negedge clk);
        timer_en = 1'b0;
        cap_mode = m;
        edge_pol = p;
        irq_src_sel = s;
        limit_val = lim;
        tmr_in = lvl;
        repeat (3) @(negedge clk);
        timer_en = 1'b1;
        t = 0;
    endtask

    initial begin
        int keep;
        int seen;
        repeat (3) @(negedge clk);
        chk("R4 reset irq", int'(irq), 0);
        chk("R3 reset capture", capv(), 0);
        chk("R5 reset status", int'(irq_is_capture), 0);
        chk("R9 reset pin", int'(tmr_out), 0);
        rst_n = 1'b1;

        // R2 R3 R4: latency sweep in free mode
        for (int j = 1; j <= 12; j++) begin
            start(2'b00, 1'b0, 2'b01, 16'd1000, 1'b0);
            go(j);
            tmr_in = 1'b1;
            go(j + 2);
            chk("R2 no early irq", int'(irq), 0);
            go(j + 3);
            chk("R2 irq after sync", int'(irq), 1);
            chk("R2 R3 captured count", capv(), j + 2);
            chk("R5 status capture", int'(irq_is_capture), 1);
            go(j + 4);
            chk("R4 single pulse", int'(irq), 0);
        end

        // R1: falling polarity, rising ignored
        start(2'b00, 1'b1, 2'b01, 16'd1000, 1'b1);
        go(2);  tmr_in = 1'b0;
        go(5);  chk("R1 falling captures", capv(), 4);
        chk("R1 falling irq", int'(irq), 1);
        go(7);  tmr_in = 1'b1;
        seen = 0;
        for (int k = 8; k <= 12; k++) begin go(k); seen += int'(irq); end
        chk("R1 rising ignored irq", seen, 0);
        chk("R1 rising ignored capture", capv(), 4);
        go(13); tmr_in = 1'b0;
        go(16); chk("R1 second falling", capv(), 15);

        // R10: level present at enable, and disabled timer
        start(2'b00, 1'b0, 2'b11, 16'd1000, 1'b1);
        keep = capv();
        seen = 0;
        for (int k = 1; k <= 8; k++) begin go(k); seen += int'(irq); end
        chk("R10 enable level no irq", seen, 0);
        chk("R10 enable level no capture", capv(), keep);
        timer_en = 1'b0;
        tmr_in = 1'b0;
        seen = 0;
        for (int k = 9; k <= 12; k++) begin go(k); if (k == 10) tmr_in = 1'b1; seen += int'(irq); end
        go(16); seen += int'(irq);
        chk("R10 disabled no events", seen, 0);
        chk("R10 disabled no capture", capv(), keep);

        // R6 R9: reload in free mode, no restart
        pin_out_en = 1'b1;
        start(2'b00, 1'b0, 2'b11, 16'd5, 1'b0);
        chk("R9 initial level", int'(tmr_out), 0);
        go(6);
        chk("R6 reload irq", int'(irq), 1);
        chk("R5 status reload", int'(irq_is_capture), 0);
        chk("R9 pin flips", int'(tmr_out), 1);
        go(7);  chk("R6 reload pulse", int'(irq), 0);
        go(10); tmr_in = 1'b1;
        go(13);
        chk("R6 counter kept running", capv(), 12);
        chk("R9 pin steady on capture", int'(tmr_out), 1);
        pin_out_en = 1'b0;
        go(14); chk("R9 pin gated off", int'(tmr_out), 0);
        pin_out_en = 1'b1;

        // R6: 16-bit wrap reaches the limit again
        start(2'b00, 1'b0, 2'b10, 16'd3, 1'b0);
        go(4);  chk("R6 first match", int'(irq), 1);
        go(65539); chk("R6 no match before wrap", int'(irq), 0);
        go(65540);
        chk("R6 match after wrap", int'(irq), 1);
        chk("R9 two flips", int'(tmr_out), 0);

        // R7: restart on capture
        start(2'b01, 1'b0, 2'b01, 16'd20, 1'b0);
        go(4);  tmr_in = 1'b1;
        go(7);  chk("R7 first capture", capv(), 6);
        go(8);  tmr_in = 1'b0;
        go(10); tmr_in = 1'b1;
        go(13);
        chk("R7 capture after restart", capv(), 6);
        chk("R7 capture irq", int'(irq), 1);

        // R7: restart on match
        start(2'b01, 1'b0, 2'b10, 16'd7, 1'b0);
        go(8);  chk("R7 match irq", int'(irq), 1);
        go(14); chk("R7 quiet before next match", int'(irq), 0);
        go(15); chk("R7 match after restart", int'(irq), 1);

        // R7: capture beats match
        start(2'b01, 1'b0, 2'b11, 16'd7, 1'b0);
        go(5);  tmr_in = 1'b1;
        go(8);
        chk("R7 coincident capture", capv(), 7);
        chk("R7 coincident status", int'(irq_is_capture), 1);
        chk("R7 no flip on coincidence", int'(tmr_out), 0);
        go(14); chk("R7 quiet after coincidence", int'(irq), 0);
        go(15);
        chk("R7 match counted from restart", int'(irq), 1);
        chk("R7 status reload", int'(irq_is_capture), 0);

        // R8: gated mode start and stop
        start(2'b10, 1'b0, 2'b11, 16'd9, 1'b0);
        keep = capv();
        go(3);  tmr_in = 1'b1;
        go(6);
        chk("R8 first edge no irq", int'(irq), 0);
        chk("R8 first edge no capture", capv(), keep);
        go(14); chk("R8 quiet before match", int'(irq), 0);
        go(15);
        chk("R8 match irq", int'(irq), 1);
        chk("R8 match status", int'(irq_is_capture), 0);
        go(16); tmr_in = 1'b0;
        go(18); tmr_in = 1'b1;
        seen = 0;
        for (int k = 19; k <= 24; k++) begin go(k); seen += int'(irq); end
        chk("R8 stopped after match", seen, 0);
        chk("R8 stopped no capture", capv(), keep);

        // R8: gated capture
        start(2'b10, 1'b0, 2'b01, 16'd50, 1'b0);
        go(3);  tmr_in = 1'b1;
        go(5);  tmr_in = 1'b0;
        go(8);  tmr_in = 1'b1;
        go(11);
        chk("R8 gated capture", capv(), 5);
        chk("R8 gated capture irq", int'(irq), 1);

        // R5: coincidence in free mode
        start(2'b00, 1'b0, 2'b11, 16'd7, 1'b0);
        go(5);  tmr_in = 1'b1;
        go(8);
        chk("R5 coincident irq", int'(irq), 1);
        chk("R5 coincident status", int'(irq_is_capture), 1);
        chk("R5 coincident capture", capv(), 7);
        chk("R9 coincident flip", int'(tmr_out), 1);

        // R4 R5: masking
        start(2'b00, 1'b0, 2'b01, 16'd5, 1'b0);
        go(6);  chk("R4 reload masked", int'(irq), 0);
        go(8);  tmr_in = 1'b1;
        go(11); chk("R4 capture enabled", int'(irq), 1);
        chk("R4 capture value", capv(), 10);
        start(2'b00, 1'b0, 2'b10, 16'd3, 1'b0);
        go(4);  chk("R4 reload enabled", int'(irq), 1);
        go(5);  tmr_in = 1'b1;
        go(8);
        chk("R4 capture masked", int'(irq), 0);
        chk("R3 masked capture stored", capv(), 7);
        chk("R5 masked keeps status", int'(irq_is_capture), 0);

        // R9: pin level with polarity 1
        start(2'b00, 1'b1, 2'b10, 16'd4, 1'b1);
        chk("R9 initial level high", int'(tmr_out), 1);
        go(5);  chk("R9 flips low", int'(tmr_out), 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule